// File: doc/BRIEF.md
# Input Transition Capture Counter

This block is a single timer channel that watches one asynchronous input pin. Each qualifying transition on the pin is counted and stamped with the value of a free-running 16-bit timer. The edge type and the timer are selectable. When the count reaches a programmed limit, the channel records a separate terminal timestamp and sets an interrupt flag.

A host sets up the channel through a small write port and reads the results back through an address-selected read port. The channel stays idle until the host issues an initialise request and gives it a non-zero priority. In single-shot mode it stops at the limit. In continual mode it starts counting again from zero.

Top module: `itc_channel`

## Requirements
- R1: After reset the transition count, both timestamps and the interrupt flag read 0, and the channel is disarmed (status bit 1 = 0).
- R2: The pin passes through a two-flop synchroniser. A pin change made before rising clock edge k is captured at edge k+2, using the timer value present at that edge.
- R3: Control bits [2:0] choose the edge: 001 rising only, 010 falling only, 011 both edges. Any other code captures nothing.
- R4: Control bit 3 chooses the time base: 0 takes `timer_a`, 1 takes `timer_b`.
- R5: Each captured transition adds one to the count, which reads back at read address 2.
- R6: Every captured transition writes its timestamp to the latest-time register (read address 3).
- R7: The terminal transition is the one that brings the count up to the limit. It stores its timestamp in the terminal-time register (read address 4) and sets the interrupt flag (output `irq`, status bit 0). A limit of 0 is treated as 1.
- R8: Single-shot mode is control bit 4 = 0. After the terminal transition the count holds at the limit, the channel disarms, and later edges change neither count nor timestamps until the next initialise.
- R9: Continual mode is control bit 4 = 1. The terminal transition resets the count to 0, the channel stays armed, and the flag stays set until the host clears it.
- R10: Edges are ignored until an initialise request has been made, and also while the priority field (control bits [6:5]) is 0.
- R11: A service write (address 2) with bit 1 set clears the flag. If a terminal transition is captured in the same cycle, the flag stays set.
- R12: A service write with bit 0 set clears the count and arms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous input pin being watched |
| timer_a | input | 16 | First free-running time base |
| timer_b | input | 16 | Second free-running time base |
| host_we | input | 1 | Write strobe |
| host_addr | input | 3 | Write address: 0 control, 1 limit, 2 service |
| host_wdata | input | 16 | Write data |
| host_raddr | input | 3 | Read address: 0 control, 1 limit, 2 count, 3 latest time, 4 terminal time, 5 status {armed, flag} |
| host_rdata | output | 16 | Read data for `host_raddr` |
| irq | output | 1 | Interrupt flag |

## Verification
Two events can fall in the same cycle: a host write that clears the flag, and the capture of a terminal transition. The bench provokes this by changing the pin and then timing the clear write so that it lands on the third rising edge after the change, which is the edge where the capture happens. It then checks that the flag still reads 1 and that the terminal timestamp holds the new capture.

// File: rtl/itc_channel.sv
module itc_channel #(
  parameter int TW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          host_we,
  input  logic [2:0]    host_addr,
  input  logic [15:0]   host_wdata,
  input  logic [2:0]    host_raddr,
  output logic [15:0]   host_rdata,
  output logic          irq
);
  logic [6:0]    ctrl;
  logic [CW-1:0] max_cnt, count;
  logic [TW-1:0] last_t, final_t;
  logic          armed, flag;
  logic          s1, s2, s3;

  wire [2:0]    edge_sel  = ctrl[2:0];
  wire          use_b     = ctrl[3];
  wire          continual = ctrl[4];
  wire [1:0]    prio      = ctrl[6:5];
  wire          init_req  = host_we && host_addr == 3'd2 && host_wdata[0];
  wire          clr_req   = host_we && host_addr == 3'd2 && host_wdata[1];
  wire          rise      = s2 && !s3;
  wire          fall      = !s2 && s3;
  wire          qual      = (edge_sel == 3'b001 && rise) || (edge_sel == 3'b010 && fall) ||
                            (edge_sel == 3'b011 && (rise || fall));
  wire          capture   = armed && prio != 2'd0 && qual && !init_req;
  wire [CW-1:0] limit     = (max_cnt == '0) ? CW'(1) : max_cnt;
  wire [CW-1:0] cnt_inc   = count + CW'(1);
  wire          terminal  = capture && cnt_inc == limit;
  wire [TW-1:0] tnow      = use_b ? timer_b : timer_a;

  assign irq = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      max_cnt <= '0;
    end else if (host_we) begin
      if (host_addr == 3'd0) ctrl    <= host_wdata[6:0];
      if (host_addr == 3'd1) max_cnt <= host_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      last_t  <= '0;
      final_t <= '0;
      armed   <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (clr_req) flag <= 1'b0;
      if (init_req) begin
        count <= '0;
        armed <= 1'b1;
      end else if (capture) begin
        last_t <= tnow;
        if (terminal) begin
          final_t <= tnow;
          flag    <= 1'b1;
          if (continual) count <= '0;
          else begin
            count <= cnt_inc;
            armed <= 1'b0;
          end
        end else begin
          count <= cnt_inc;
        end
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_raddr)
      3'd0: host_rdata = {9'd0, ctrl};
      3'd1: host_rdata = 16'(max_cnt);
      3'd2: host_rdata = 16'(count);
      3'd3: host_rdata = 16'(last_t);
      3'd4: host_rdata = 16'(final_t);
      3'd5: host_rdata = {14'd0, armed, flag};
      default: host_rdata = '0;
    endcase
  end
endmodule

module itc_channel_chk #(
  parameter int TW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic [TW-1:0] final_t,
  input logic          armed,
  input logic          flag,
  input logic          init_req,
  input logic          clr_req,
  input logic [6:0]    ctrl
);
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |-> (count == $past(count) + CW'(1) || count == '0));
  p_final_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    final_t != $past(final_t) |-> flag);
  p_single_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> flag && !$past(ctrl[4]));
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6:5] == 2'd0 && !init_req) |=> $stable(count));
  p_clear_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_req));
  p_init_arms_r12: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> armed && count == '0);
endmodule

bind itc_channel itc_channel_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .final_t(final_t), .armed(armed),
  .flag(flag), .init_req(init_req), .clr_req(clr_req), .ctrl(ctrl)
);

// File: tb/sim_itc_channel.sv
module sim_itc_channel;
  logic        clk = 1'b0, rst_n = 1'b0, pin_in = 1'b0;
  logic [15:0] timer_a = '0, timer_b = '0, host_wdata = '0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0, host_raddr = '0;
  logic [15:0] host_rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  itc_channel u0 (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    host_raddr = a;
    #1 d = host_rdata;
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] e);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, e);
  endtask

  task automatic t_reset;
    expect_reg("R1 count", 3'd2, 16'd0);
    expect_reg("R1 last", 3'd3, 16'd0);
    expect_reg("R1 final", 3'd4, 16'd0);
    expect_reg("R1 status", 3'd5, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_inactive;
    wr(3'd0, 16'h0021);
    timer_a = 16'd5;
    pin(1'b1); pin(1'b0);
    expect_reg("R10 no init", 3'd2, 16'd0);
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0001);
    pin(1'b1); pin(1'b0);
    expect_reg("R10 prio zero", 3'd2, 16'd0);
    expect_reg("R10 last unchanged", 3'd3, 16'd0);
  endtask

  task automatic t_single;
    wr(3'd0, 16'h0021);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'h0001);
    expect_reg("R12 armed", 3'd5, 16'h0002);
    timer_a = 16'd100; pin(1'b1);
    timer_a = 16'd150; pin(1'b0);
    expect_reg("R5 count 1", 3'd2, 16'd1);
    expect_reg("R6 last", 3'd3, 16'd100);
    timer_a = 16'd200; pin(1'b1); pin(1'b0);
    timer_a = 16'd300; pin(1'b1);
    expect_reg("R8 count at max", 3'd2, 16'd3);
    expect_reg("R7 final", 3'd4, 16'd300);
    expect_reg("R8 disarmed flag set", 3'd5, 16'h0001);
    chk("R7 irq", {15'd0, irq}, 16'd1);
    pin(1'b0);
    timer_a = 16'd400; pin(1'b1);
    expect_reg("R8 ignored count", 3'd2, 16'd3);
    expect_reg("R8 ignored last", 3'd3, 16'd300);
    wr(3'd2, 16'h0002);
    chk("R11 cleared", {15'd0, irq}, 16'd0);
    pin(1'b0);
  endtask

  task automatic t_edges;
    wr(3'd0, 16'h0022);
    wr(3'd1, 16'd9);
    wr(3'd2, 16'h0001);
    timer_a = 16'd40; pin(1'b1);
    expect_reg("R3 falling ignores rise", 3'd2, 16'd0);
    timer_a = 16'd50; pin(1'b0);
    expect_reg("R3 falling counted", 3'd2, 16'd1);
    expect_reg("R3 falling time", 3'd3, 16'd50);
    wr(3'd0, 16'h0023);
    wr(3'd2, 16'h0001);
    pin(1'b1); pin(1'b0);
    expect_reg("R3 both edges", 3'd2, 16'd2);
    wr(3'd0, 16'h0027);
    pin(1'b1); pin(1'b0);
    expect_reg("R3 code 111 none", 3'd2, 16'd2);
  endtask

  task automatic t_timer_b;
    wr(3'd0, 16'h0029);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'h0003);
    timer_a = 16'd111; timer_b = 16'd777;
    pin(1'b1);
    expect_reg("R4 timer b final", 3'd4, 16'd777);
    expect_reg("R4 timer b last", 3'd3, 16'd777);
    pin(1'b0);
  endtask

  task automatic t_max0;
    wr(3'd0, 16'h0021);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'h0003);
    timer_a = 16'd66; pin(1'b1);
    chk("R7 max zero irq", {15'd0, irq}, 16'd1);
    expect_reg("R7 max zero count", 3'd2, 16'd1);
    pin(1'b0);
  endtask

  task automatic t_sync_lag;
    logic [15:0] d;
    wr(3'd0, 16'h0021);
    wr(3'd1, 16'd9);
    wr(3'd2, 16'h0003);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(3'd2, d);
    chk("R2 not yet at edge 2", d, 16'd0);
    @(negedge clk);
    rd(3'd2, d);
    chk("R2 captured at edge 3", d, 16'd1);
    pin(1'b0);
  endtask

  task automatic t_continual;
    wr(3'd0, 16'h0031);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'h0003);
    timer_a = 16'd10; pin(1'b1); pin(1'b0);
    timer_a = 16'd20; pin(1'b1); pin(1'b0);
    expect_reg("R9 count wraps", 3'd2, 16'd0);
    expect_reg("R9 final", 3'd4, 16'd20);
    timer_a = 16'd30; pin(1'b1);
    expect_reg("R9 keeps counting", 3'd2, 16'd1);
    expect_reg("R9 last", 3'd3, 16'd30);
    expect_reg("R9 flag held armed", 3'd5, 16'h0003);
    pin(1'b0);
  endtask

  task automatic t_race;
    wr(3'd0, 16'h0031);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'h0003);
    timer_a = 16'd900;
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); host_we = 1'b1; host_addr = 3'd2; host_wdata = 16'h0002;
    @(negedge clk); host_we = 1'b0;
    chk("R11 capture beats clear", {15'd0, irq}, 16'd1);
    expect_reg("R11 final on race", 3'd4, 16'd900);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_inactive;
    t_single;
    t_edges;
    t_timer_b;
    t_max0;
    t_sync_lag;
    t_continual;
    t_race;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule